// File: doc/BRIEF.md
# PRBS-15 Link Self-Test Checker with Error Counter

This block checks a serial bit stream for a link self-test. It accepts one received bit per clock, qualified by a valid strobe. The checker expects a PRBS-15 sequence. It seeds its prediction register directly from the incoming bits and declares lock once a long enough run of bits matches its prediction. While locked, it counts every mismatched bit in an error counter.

When errors bunch together, the checker decides that it has lost synchronisation. It drops lock, sets a sticky flag and starts seeding again. The error counter either freezes at full scale or wraps to zero. When it wraps, it emits a one-cycle rollover pulse.

A matching PRBS-15 generator is included, so the same block can drive the transmit side of a loopback test. A two-bit enable field selects which halves run. A clear strobe resets the counter and the sticky flag.

Top module: `prbs_selftest`

## Requirements
- R1: Enable field `en_field`: bit 0 runs the generator and bit 1 runs the checker (0 = both off, 1 = generator only, 2 = checker only, 3 = both). `gen_active` is high exactly when bit 0 is set. `tx_valid` is high in the cycle after each edge that samples bit 0 set, and low in the cycle after an edge that samples it clear.
- R2: The generator keeps its last 15 output bits, starting from all ones (parameter `GEN_SEED`). At each enabled edge it emits the XOR of the oldest bit and the second-oldest bit on `tx_bit`, then shifts that bit in. The result is the sequence b[n] = b[n-15] XOR b[n-14].
- R3: Once enabled, the checker treats its first 15 valid bits as the seed. It raises `locked` at the edge of the 32nd consecutive correctly predicted valid bit after that, which is the 47th valid bit overall. Cycles with `rx_valid` low neither advance nor disturb this.
- R4: A mispredicted bit before lock is reached sends the checker back to seeding. A further 15 + 32 valid bits are then needed for lock.
- R5: While locked, the reference sequence runs freely. Each valid bit that differs from it increments `err_count` by exactly one. No increment happens while the checker is unlocked.
- R6: Lock time is cut into blocks of 64 valid bits, aligned to the edge where lock was gained. The 8th mismatch inside one block has three effects in the same edge: it drops `locked`, sets `sync_lost` and restarts seeding. Seven mismatches in a block do not drop lock, and the mismatch tally restarts with each new block.
- R7: `sync_lost` stays high until `clr` is sampled high. A loss event in the same edge as `clr` leaves it set.
- R8: With `cnt_wrap` = 0 (single mode), `err_count` stops at its maximum value and holds it.
- R9: With `cnt_wrap` = 1 (continuous mode), an increment at the maximum value wraps `err_count` to zero. In that same cycle, `err_wrap_pulse` is high for exactly one cycle.
- R10: `clr` clears `err_count` at the next edge and takes priority over an increment in the same cycle.
- R11: Clearing bit 1 of `en_field` drops `locked`, clears `err_count` and restarts seeding. It does not change `sync_lost`.
- R12: While reset (`rst_n` low) is applied, all outputs except `gen_active` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_field | input | 2 | Generator/checker enable field |
| cnt_wrap | input | 1 | Error counter end behaviour: 0 freeze, 1 wrap |
| clr | input | 1 | Clears error counter and sync-loss flag |
| rx_valid | input | 1 | Received bit qualifier |
| rx_bit | input | 1 | Received bit |
| tx_valid | output | 1 | Generator bit qualifier |
| tx_bit | output | 1 | Generated bit |
| gen_active | output | 1 | Generator enabled status |
| locked | output | 1 | Checker locked to the stream |
| sync_lost | output | 1 | Sticky loss-of-synchronisation flag |
| err_count | output | ERR_W | Bit error count |
| err_wrap_pulse | output | 1 | One-cycle counter rollover pulse |

## Verification
Two pairs of functions can act in the same edge, and the bench forces both. In the first pair, the 8th mismatch of a 64-bit block both increments the error counter and ends lock. The bench sends exactly eight flipped bits into a fresh block and then checks three things right after that edge: `locked` is low, `sync_lost` is high, and the count is eight. In the second pair, a clear strobe meets a counted error. The bench drives `clr` together with a flipped bit while locked and expects a zero count, because the clear wins.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int PRBS_LEN = 15;
    localparam int TAP_HI   = 14;
    localparam int TAP_LO   = 13;

    typedef logic [PRBS_LEN-1:0] prbs_sr_t;

    typedef enum logic [1:0] {
        SYNC_SEED   = 2'd0,
        SYNC_VERIFY = 2'd1,
        SYNC_LOCKED = 2'd2
    } sync_state_e;

    // next sequence bit from the last PRBS_LEN bits (bit PRBS_LEN-1 oldest)
    function automatic logic prbs_fb(input prbs_sr_t sr);
        return sr[TAP_HI] ^ sr[TAP_LO];
    endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_pkg::*;
#(
    parameter prbs_sr_t SEED = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tx_valid,
    output logic tx_bit
);

    typedef struct packed {
        prbs_sr_t sr;
        logic     vld;
        logic     dat;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d     = gen_q;
        gen_d.vld = run;
        if (run) begin
            gen_d.dat = prbs_fb(gen_q.sr);
            gen_d.sr  = {gen_q.sr[PRBS_LEN-2:0], prbs_fb(gen_q.sr)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{sr: SEED, vld: 1'b0, dat: 1'b0};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign tx_valid = gen_q.vld;
    assign tx_bit   = gen_q.dat;

endmodule

// File: rtl/prbs_sync.sv
module prbs_sync
    import prbs_pkg::*;
#(
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic in_valid,
    input  logic in_bit,
    output logic locked,
    output logic err_hit,
    output logic loss_evt
);

    localparam int CNT_MAX = (LOCK_RUN > PRBS_LEN) ? LOCK_RUN : PRBS_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int WIN_W   = $clog2(WIN_LEN);
    localparam int WERR_W  = $clog2(LOSS_ERRS + 1);

    typedef struct packed {
        sync_state_e       st;
        prbs_sr_t          hist;
        logic [CNT_W-1:0]  cnt;
        logic [WIN_W-1:0]  win;
        logic [WERR_W-1:0] werr;
    } sync_t;

    sync_t s_d, s_q;
    logic  pred;
    logic  miss;

    assign pred = prbs_fb(s_q.hist);
    assign miss = in_bit ^ pred;

    always_comb begin
        s_d      = s_q;
        err_hit  = 1'b0;
        loss_evt = 1'b0;
        if (!enable) begin
            s_d = '{st: SYNC_SEED, hist: '0, cnt: '0, win: '0, werr: '0};
        end else if (in_valid) begin
            unique case (s_q.st)
                SYNC_SEED: begin
                    s_d.hist = {s_q.hist[PRBS_LEN-2:0], in_bit};
                    if (s_q.cnt == CNT_W'(PRBS_LEN - 1)) begin
                        s_d.st  = SYNC_VERIFY;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                SYNC_VERIFY: begin
                    s_d.hist = {s_q.hist[PRBS_LEN-2:0], in_bit};
                    if (miss) begin
                        s_d.st  = SYNC_SEED;
                        s_d.cnt = '0;
                    end else if (s_q.cnt == CNT_W'(LOCK_RUN - 1)) begin
                        s_d.st   = SYNC_LOCKED;
                        s_d.cnt  = '0;
                        s_d.win  = '0;
                        s_d.werr = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                SYNC_LOCKED: begin
                    // reference runs freely once locked
                    s_d.hist = {s_q.hist[PRBS_LEN-2:0], pred};
                    err_hit  = miss;
                    if (miss && (s_q.werr == WERR_W'(LOSS_ERRS - 1))) begin
                        loss_evt = 1'b1;
                        s_d.st   = SYNC_SEED;
                        s_d.cnt  = '0;
                    end else if (s_q.win == WIN_W'(WIN_LEN - 1)) begin
                        s_d.win  = '0;
                        s_d.werr = '0;
                    end else begin
                        s_d.win  = s_q.win + 1'b1;
                        s_d.werr = s_q.werr + WERR_W'(miss);
                    end
                end
                default: s_d.st = SYNC_SEED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SYNC_SEED, hist: '0, cnt: '0, win: '0, werr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign locked = (s_q.st == SYNC_LOCKED);

endmodule

// File: rtl/err_counter.sv
module err_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic         wrap_mode,
    output logic [W-1:0] count,
    output logic         wrap_pulse
);

    localparam logic [W-1:0] FULL = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.pulse = 1'b0;
        if (clear) begin
            c_d.cnt = '0;
        end else if (inc) begin
            if (c_q.cnt != FULL) begin
                c_d.cnt = c_q.cnt + 1'b1;
            end else if (wrap_mode) begin
                c_d.cnt   = '0;
                c_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{cnt: '0, pulse: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign count      = c_q.cnt;
    assign wrap_pulse = c_q.pulse;

endmodule

// File: rtl/prbs_selftest.sv
module prbs_selftest
    import prbs_pkg::*;
#(
    parameter int       ERR_W     = 16,
    parameter int       LOCK_RUN  = 32,
    parameter int       WIN_LEN   = 64,
    parameter int       LOSS_ERRS = 8,
    parameter prbs_sr_t GEN_SEED  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       en_field,
    input  logic             cnt_wrap,
    input  logic             clr,
    input  logic             rx_valid,
    input  logic             rx_bit,
    output logic             tx_valid,
    output logic             tx_bit,
    output logic             gen_active,
    output logic             locked,
    output logic             sync_lost,
    output logic [ERR_W-1:0] err_count,
    output logic             err_wrap_pulse
);

    localparam int EN_GEN = 0;
    localparam int EN_CHK = 1;

    logic err_hit;
    logic loss_evt;
    logic lost_d, lost_q;

    prbs_gen #(
        .SEED (GEN_SEED)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_field[EN_GEN]),
        .tx_valid (tx_valid),
        .tx_bit   (tx_bit)
    );

    prbs_sync #(
        .LOCK_RUN  (LOCK_RUN),
        .WIN_LEN   (WIN_LEN),
        .LOSS_ERRS (LOSS_ERRS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (en_field[EN_CHK]),
        .in_valid (rx_valid),
        .in_bit   (rx_bit),
        .locked   (locked),
        .err_hit  (err_hit),
        .loss_evt (loss_evt)
    );

    err_counter #(
        .W (ERR_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clr | ~en_field[EN_CHK]),
        .inc        (err_hit),
        .wrap_mode  (cnt_wrap),
        .count      (err_count),
        .wrap_pulse (err_wrap_pulse)
    );

    // sticky loss flag: a new loss wins over a clear
    always_comb begin
        lost_d = lost_q;
        if (loss_evt) begin
            lost_d = 1'b1;
        end else if (clr) begin
            lost_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_q <= 1'b0;
        end else begin
            lost_q <= lost_d;
        end
    end

    assign sync_lost  = lost_q;
    assign gen_active = en_field[EN_GEN];

endmodule

// File: rtl/prbs_selftest_chk.sv
module prbs_selftest_chk #(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       en_field,
    input logic             cnt_wrap,
    input logic             clr,
    input logic             locked,
    input logic             sync_lost,
    input logic [ERR_W-1:0] err_count,
    input logic             err_wrap_pulse
);

    localparam logic [ERR_W-1:0] FULL = {ERR_W{1'b1}};

    assert_chk_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_field[1] |=> (!locked && err_count == '0));

    assert_sticky_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lost && !clr) |=> sync_lost);

    assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked) && $past(en_field[1])) |-> sync_lost);

    assert_hold_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wrap && en_field[1] && !clr && err_count == FULL) |=> err_count == FULL);

    assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_wrap_pulse |-> err_count == '0);

    assert_pulse_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_wrap_pulse |=> !err_wrap_pulse);

    assert_clr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> err_count == '0);

    assert_no_count_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !clr && en_field[1]) |=> $stable(err_count));

endmodule

bind prbs_selftest prbs_selftest_chk #(.ERR_W(ERR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_field       (en_field),
    .cnt_wrap       (cnt_wrap),
    .clr            (clr),
    .locked         (locked),
    .sync_lost      (sync_lost),
    .err_count      (err_count),
    .err_wrap_pulse (err_wrap_pulse)
);

// File: tb/test_prbs_selftest.sv
module test_prbs_selftest;

    localparam int CLK_PERIOD = 10;
    localparam int EW         = 4;
    localparam int SEED_BITS  = 15;
    localparam int RUN_BITS   = 32;

    // columns: flipped bits, good bits after, exp locked, exp sync_lost, exp count
    localparam int NV = 5;
    localparam int VTAB [0:NV-1][0:4] = '{
        '{0, 10, 1, 0, 0},
        '{1,  0, 1, 0, 1},
        '{5,  3, 1, 0, 5},
        '{7, 57, 1, 0, 7},
        '{8,  0, 0, 1, 8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    en_field = 2'd0;
    logic          cnt_wrap = 1'b0;
    logic          clr = 1'b0;
    logic          rx_valid = 1'b0;
    logic          rx_bit = 1'b0;
    logic          tx_valid, tx_bit, gen_active, locked, sync_lost, err_wrap_pulse;
    logic [EW-1:0] err_count;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic [14:0] mdl;
    int   pulses;

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_selftest #(.ERR_W(EW)) i_prbs_selftest (
        .clk(clk), .rst_n(rst_n), .en_field(en_field), .cnt_wrap(cnt_wrap),
        .clr(clr), .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_valid(tx_valid),
        .tx_bit(tx_bit), .gen_active(gen_active), .locked(locked),
        .sync_lost(sync_lost), .err_count(err_count), .err_wrap_pulse(err_wrap_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic mdl_next();
        logic b;
        b   = mdl[14] ^ mdl[13];
        mdl = {mdl[13:0], b};
        return b;
    endfunction

    // one clock; called and returns at a falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        clr      = 1'b0;
        if (err_wrap_pulse) pulses++;
    endtask

    task automatic push(input logic b);
        rx_valid = 1'b1;
        rx_bit   = b;
        tick();
    endtask

    task automatic send_good(input int n);
        for (int i = 0; i < n; i++) push(mdl_next());
    endtask

    task automatic send_bad(input int n);
        for (int i = 0; i < n; i++) push(~mdl_next());
    endtask

    task automatic restart_checker();
        en_field = 2'd0;
        clr      = 1'b1;
        tick();
        en_field = 2'd2;
        mdl      = 15'h5A3C;
        pulses   = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        en_field = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 tx_valid", int'(tx_valid), 0);
        check("R12 locked", int'(locked), 0);
        check("R12 sync_lost", int'(sync_lost), 0);
        check("R12 err_count", int'(err_count), 0);
        check("R12 wrap pulse", int'(err_wrap_pulse), 0);
        en_field = 2'd0;
        rst_n = 1'b1;
        tick();

        // R1/R2: generator only
        en_field = 2'd1;
        mdl = 15'h7FFF;
        tick();
        check("R1 gen_active", int'(gen_active), 1);
        check("R1 tx_valid on", int'(tx_valid), 1);
        begin
            int bad = 0;
            for (int i = 0; i < 40; i++) begin
                if (tx_bit !== mdl_next()) bad++;
                tick();
            end
            check("R2 sequence mismatches", bad, 0);
        end
        check("R1 checker idle when gen only", int'(locked), 0);
        en_field = 2'd2;
        tick();
        check("R1 tx_valid off", int'(tx_valid), 0);
        check("R1 gen_active off", int'(gen_active), 0);

        // R1/R3: loopback with both enabled, 47 bits to lock
        en_field = 2'd3;
        tick();
        for (int i = 0; i < SEED_BITS + RUN_BITS; i++) begin
            rx_valid = tx_valid;
            rx_bit   = tx_bit;
            tick();
        end
        check("R3 loopback locked", int'(locked), 1);
        check("R5 loopback errors", int'(err_count), 0);

        // R3: lock timing with idle gaps carrying junk
        restart_checker();
        for (int i = 0; i < SEED_BITS + RUN_BITS - 1; i++) begin
            push(mdl_next());
            rx_bit = ~rx_bit;
            tick();
        end
        check("R3 not locked at 46", int'(locked), 0);
        send_good(1);
        check("R3 locked at 47", int'(locked), 1);

        // R4: mismatch during verify restarts seeding
        restart_checker();
        send_good(SEED_BITS + 10);
        send_bad(1);
        send_good(SEED_BITS + RUN_BITS - 1);
        check("R4 not locked after reseed 46", int'(locked), 0);
        send_good(1);
        check("R4 locked after reseed 47", int'(locked), 1);
        check("R4 no errors counted", int'(err_count), 0);

        // R5/R6: vector table walk
        for (int v = 0; v < NV; v++) begin
            restart_checker();
            send_good(SEED_BITS + RUN_BITS);
            send_bad(VTAB[v][0]);
            send_good(VTAB[v][1]);
            check($sformatf("R6 vec%0d locked", v), int'(locked), VTAB[v][2]);
            check($sformatf("R6 vec%0d sync_lost", v), int'(sync_lost), VTAB[v][3]);
            check($sformatf("R5 vec%0d err_count", v), int'(err_count), VTAB[v][4]);
        end

        // R7: sticky flag held across bits and disable, cleared by clr
        send_good(20);
        check("R7 sync_lost held", int'(sync_lost), 1);
        en_field = 2'd0;
        tick();
        check("R11 disable keeps sync_lost", int'(sync_lost), 1);
        clr = 1'b1;
        tick();
        check("R7 clr clears sync_lost", int'(sync_lost), 0);

        // R6: block boundary resets the tally (7 + 7 across two blocks)
        restart_checker();
        send_good(SEED_BITS + RUN_BITS);
        send_bad(7);
        send_good(57);
        send_bad(7);
        check("R6 two blocks still locked", int'(locked), 1);
        check("R6 two blocks count", int'(err_count), 14);
        check("R6 two blocks no loss", int'(sync_lost), 0);

        // R11: disable while locked clears count and lock
        en_field = 2'd0;
        tick();
        check("R11 locked cleared", int'(locked), 0);
        check("R11 count cleared", int'(err_count), 0);

        // R10: clr with an error in the same cycle
        restart_checker();
        send_good(SEED_BITS + RUN_BITS);
        send_bad(3);
        clr = 1'b1;
        send_bad(1);
        check("R10 clr beats increment", int'(err_count), 0);
        send_bad(1);
        check("R10 counting resumes", int'(err_count), 1);

        // R8: single mode saturates at 15
        cnt_wrap = 1'b0;
        restart_checker();
        send_good(SEED_BITS + RUN_BITS);
        for (int k = 0; k < 3; k++) begin
            send_bad(7);
            send_good(57);
        end
        check("R8 saturated count", int'(err_count), 15);
        check("R8 no pulse", pulses, 0);

        // R9: continuous mode wraps once
        cnt_wrap = 1'b1;
        restart_checker();
        send_good(SEED_BITS + RUN_BITS);
        for (int k = 0; k < 3; k++) begin
            send_bad(7);
            send_good(57);
        end
        check("R9 wrapped count", int'(err_count), 5);
        check("R9 one pulse", pulses, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule